// File: doc/BRIEF.md
# Ethernet PHY Basic Control and Status Registers

This block holds the two basic management registers of a 10/100 Ethernet transceiver: a control word that drives the datapath and a status word that reports link conditions. Software reads and writes them through a plain address, data and strobe port. The serial management framing is handled outside this block, and so are the identifier and negotiation registers.

The control word has writable mode bits (loopback, speed, negotiation enable, low power, isolate, duplex) and two command bits that clear themselves: a soft reset and a negotiation restart. The soft reset holds for a parameterised number of clocks and puts every mode bit back to its default. The isolate default depends on the strapped management address. The status word combines constant capability bits with event bits that latch until read. Link status latches low. Negotiation-complete, remote-fault and jabber latch high. Each of these bits goes back to tracking its live condition on the clock after a read.

Top module: `phy_mgmt_regs`

## Requirements
- R1: After hardware reset with a nonzero strap, the control word (address 0) reads 0x3100: speed 100 (bit 13), negotiation enabled (bit 12) and full duplex (bit 8) are 1, all other bits are 0. `acc_rdata` is 0 until the first read.
- R2: A write to address 0 sets loopback (bit 14), speed (13), negotiation enable (12), low power (11), isolate (10) and duplex (8). These bits drive the matching outputs and read back. Bits 7 to 0 always read 0.
- R3: Writing bit 15 as 1 starts a soft reset. `soft_rst` is high for SRST_CYC cycles and bit 15 reads 1 during that time. The mode bits go to their defaults, writes are ignored until the soft reset ends, and bit 15 then reads 0.
- R4: Writing bit 9 as 1 (with bit 15 as 0) raises `an_restart` for exactly one cycle, starting in the cycle after the write. Bit 9 then reads 0.
- R5: Status bit 2 (link) latches low. After `link_up` has been 0 on any clock edge, the bit reads 0 until a status read, even if the link returns. It also reads 0 on the first read after hardware reset.
- R6: Status bits 5 (`an_done`), 4 (`rem_fault`) and 1 (`jabber`) latch high. An event seen on any clock edge is reported as 1 by the next status read.
- R7: Status bits 15 and 10 to 6 always read 0. Bits 3 and 0 always read 1. Bits 14 to 11 read the ABIL parameter, which defaults to 4'b1111.
- R8: On the clock of a status read, each latched bit is reloaded from its live input. An event that is present only on the read edge is reported by the following read.
- R9: Writes to address 1 change nothing. Reads of any address other than 0 or 1 return 0.
- R10: `acc_rdata` changes only on a clock where `acc_rd` is high, and becomes valid one cycle after the strobe.
- R11: When `strap_addr` is zero during hardware reset or soft reset, isolate (bit 10) defaults to 1, so the control word reads 0x3500.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| strap_addr | input | STRAP_W | Strapped management address; zero selects isolate by default |
| acc_addr | input | REG_AW | Register address |
| acc_wr | input | 1 | Write strobe |
| acc_rd | input | 1 | Read strobe; a status read clears the latched bits |
| acc_wdata | input | 16 | Write data |
| acc_rdata | output | 16 | Registered read data |
| link_up | input | 1 | Live link condition |
| an_done | input | 1 | Live negotiation-complete event |
| rem_fault | input | 1 | Live remote-fault event |
| jabber | input | 1 | Live jabber event |
| loopback | output | 1 | Loopback mode |
| speed_100 | output | 1 | 1 selects 100 Mb/s |
| an_enable | output | 1 | Negotiation enable |
| an_restart | output | 1 | Single-cycle negotiation restart pulse |
| low_power | output | 1 | Low-power mode |
| isolate | output | 1 | Isolate datapath interface |
| full_duplex | output | 1 | 1 selects full duplex |
| soft_rst | output | 1 | Soft reset in progress |

## Verification
If a latch bit held a wrong value, the error would show up in the next status read. It could also show up one read later, because the reload-on-read rule makes a missed clear and a missed event visible on consecutive reads. A wrong soft-reset count shows directly as the length of the `soft_rst` pulse. A write that is not blocked during soft reset shows as a control word that differs from its defaults on the first read after the pulse. A restart bit that fails to clear shows as `an_restart` staying high longer than one cycle, and as bit 9 reading 1 afterwards.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;

   localparam int unsigned REG_W = 16;

   // control word bit positions
   localparam int unsigned C_SRST = 15;
   localparam int unsigned C_LOOP = 14;
   localparam int unsigned C_SPD  = 13;
   localparam int unsigned C_ANEN = 12;
   localparam int unsigned C_LPWR = 11;
   localparam int unsigned C_ISO  = 10;
   localparam int unsigned C_ANRS = 9;
   localparam int unsigned C_DPLX = 8;

   // latch-high event index
   localparam int unsigned EV_N    = 3;
   localparam int unsigned EV_AND  = 0;
   localparam int unsigned EV_RF   = 1;
   localparam int unsigned EV_JAB  = 2;

   typedef struct packed {
      logic loop;
      logic spd;
      logic anen;
      logic lpwr;
      logic iso;
      logic dplx;
   } ctrl_t;

   function automatic ctrl_t ctrl_dflt(input logic iso_d);
      ctrl_t c;
      c.loop = 1'b0;
      c.spd  = 1'b1;
      c.anen = 1'b1;
      c.lpwr = 1'b0;
      c.iso  = iso_d;
      c.dplx = 1'b1;
      return c;
   endfunction

endpackage

// File: rtl/phy_ctrl_reg.sv
module phy_ctrl_reg
   import phy_mgmt_pkg::*;
#(
   parameter int unsigned SRST_CYC = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             iso_dflt,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wdata,
   output ctrl_t            ctrl_o,
   output logic             srst_o,
   output logic             anrs_o,
   output logic [REG_W-1:0] rdata_o
);

   localparam int unsigned CW = $clog2(SRST_CYC + 1);

   initial begin : elab_chk
      assert (SRST_CYC >= 1) else $error("SRST_CYC must be at least 1");
   end

   ctrl_t          ctrl_q;
   logic [CW-1:0]  cnt_q;
   logic           anrs_q;
   logic           busy;

   assign busy = (cnt_q != '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q <= ctrl_dflt(iso_dflt);
         cnt_q  <= '0;
         anrs_q <= 1'b0;
      end else begin
         anrs_q <= 1'b0;
         if (busy) cnt_q <= cnt_q - 1'b1;
         if (wr_en && !busy) begin
            if (wdata[C_SRST]) begin
               ctrl_q <= ctrl_dflt(iso_dflt);
               cnt_q  <= CW'(SRST_CYC);
            end else begin
               ctrl_q.loop <= wdata[C_LOOP];
               ctrl_q.spd  <= wdata[C_SPD];
               ctrl_q.anen <= wdata[C_ANEN];
               ctrl_q.lpwr <= wdata[C_LPWR];
               ctrl_q.iso  <= wdata[C_ISO];
               ctrl_q.dplx <= wdata[C_DPLX];
               anrs_q      <= wdata[C_ANRS];
            end
         end
      end
   end

   assign ctrl_o  = ctrl_q;
   assign srst_o  = busy;
   assign anrs_o  = anrs_q;
   assign rdata_o = {busy, ctrl_q.loop, ctrl_q.spd, ctrl_q.anen, ctrl_q.lpwr,
                     ctrl_q.iso, anrs_q, ctrl_q.dplx, 8'h00};

   // R3: soft reset leaves the mode bits at their defaults
   p_srst_dflt_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (ctrl_q == ctrl_dflt(iso_dflt)));
   // R3: mode bits frozen while soft reset runs
   p_srst_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(ctrl_q));
   // R4: restart is a single-cycle pulse
   p_anrs_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      anrs_q |=> !anrs_q);
   // R4: restart only follows an accepted write of bit 9
   p_anrs_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(anrs_q) |-> $past(wr_en && !busy && wdata[C_ANRS] && !wdata[C_SRST]));

endmodule

// File: rtl/phy_stat_reg.sv
module phy_stat_reg
   import phy_mgmt_pkg::*;
#(
   parameter logic [3:0] ABIL = 4'b1111
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_clr,
   input  logic             link_i,
   input  logic [EV_N-1:0]  evt_i,
   output logic [REG_W-1:0] rdata_o
);

   logic            link_q;
   logic [EV_N-1:0] lh_q;

   // link: latch low
   always_ff @(posedge clk) begin
      if (!rst_n)      link_q <= 1'b0;
      else if (rd_clr) link_q <= link_i;
      else             link_q <= link_q & link_i;
   end

   p_ll_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!link_i && !rd_clr) |=> !link_q);
   p_ll_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_clr |=> (link_q == $past(link_i)));

   // events: latch high
   for (genvar g = 0; g < EV_N; g++) begin : g_lh
      always_ff @(posedge clk) begin
         if (!rst_n)      lh_q[g] <= 1'b0;
         else if (rd_clr) lh_q[g] <= evt_i[g];
         else             lh_q[g] <= lh_q[g] | evt_i[g];
      end

      p_lh_catch_r6: assert property (@(posedge clk) disable iff (!rst_n)
         ((evt_i[g] || lh_q[g]) && !rd_clr) |=> lh_q[g]);
      p_lh_reload_r8: assert property (@(posedge clk) disable iff (!rst_n)
         rd_clr |=> (lh_q[g] == $past(evt_i[g])));
   end

   assign rdata_o = {1'b0, ABIL, 5'b00000,
                     lh_q[EV_AND], lh_q[EV_RF], 1'b1,
                     link_q, lh_q[EV_JAB], 1'b1};

endmodule

// File: rtl/phy_mgmt_regs.sv
module phy_mgmt_regs
   import phy_mgmt_pkg::*;
#(
   parameter int unsigned REG_AW    = 5,
   parameter int unsigned STRAP_W   = 5,
   parameter int unsigned CTRL_ADDR = 0,
   parameter int unsigned STAT_ADDR = 1,
   parameter int unsigned SRST_CYC  = 8,
   parameter logic [3:0]  ABIL      = 4'b1111
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [STRAP_W-1:0] strap_addr,
   input  logic [REG_AW-1:0]  acc_addr,
   input  logic               acc_wr,
   input  logic               acc_rd,
   input  logic [15:0]        acc_wdata,
   output logic [15:0]        acc_rdata,
   input  logic               link_up,
   input  logic               an_done,
   input  logic               rem_fault,
   input  logic               jabber,
   output logic               loopback,
   output logic               speed_100,
   output logic               an_enable,
   output logic               an_restart,
   output logic               low_power,
   output logic               isolate,
   output logic               full_duplex,
   output logic               soft_rst
);

   localparam int unsigned NREG = 2 ** REG_AW;

   initial begin : elab_chk
      assert (CTRL_ADDR != STAT_ADDR) else $error("register addresses collide");
      assert (CTRL_ADDR < NREG && STAT_ADDR < NREG) else $error("address out of range");
      assert (STRAP_W >= 1) else $error("STRAP_W must be at least 1");
   end

   logic             sel_ctrl, sel_stat;
   logic             iso_dflt;
   ctrl_t            ctrl;
   logic [REG_W-1:0] ctrl_rd, stat_rd;
   logic [EV_N-1:0]  evt;
   logic [15:0]      rdata_q;

   assign sel_ctrl = (acc_addr == REG_AW'(CTRL_ADDR));
   assign sel_stat = (acc_addr == REG_AW'(STAT_ADDR));
   assign iso_dflt = (strap_addr == '0);

   assign evt[EV_AND] = an_done;
   assign evt[EV_RF]  = rem_fault;
   assign evt[EV_JAB] = jabber;

   phy_ctrl_reg #(.SRST_CYC(SRST_CYC)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .iso_dflt(iso_dflt),
      .wr_en   (acc_wr && sel_ctrl),
      .wdata   (acc_wdata),
      .ctrl_o  (ctrl),
      .srst_o  (soft_rst),
      .anrs_o  (an_restart),
      .rdata_o (ctrl_rd)
   );

   phy_stat_reg #(.ABIL(ABIL)) u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_clr (acc_rd && sel_stat),
      .link_i (link_up),
      .evt_i  (evt),
      .rdata_o(stat_rd)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)      rdata_q <= '0;
      else if (acc_rd) rdata_q <= sel_ctrl ? ctrl_rd : (sel_stat ? stat_rd : '0);
   end

   assign acc_rdata   = rdata_q;
   assign loopback    = ctrl.loop;
   assign speed_100   = ctrl.spd;
   assign an_enable   = ctrl.anen;
   assign low_power   = ctrl.lpwr;
   assign isolate     = ctrl.iso;
   assign full_duplex = ctrl.dplx;

   // R7: constant status fields as seen at the port
   p_fixed_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && sel_stat) |=> (!acc_rdata[15] && acc_rdata[3] && acc_rdata[0]
                                && acc_rdata[10:6] == 5'b0 && acc_rdata[14:11] == ABIL));
   // R10: read data only moves on a read strobe
   p_rdata_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !acc_rd |=> $stable(acc_rdata));
   // R2: control low byte reads zero
   p_ctrl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_rd && sel_ctrl) |=> (acc_rdata[7:0] == 8'h00));

endmodule

// File: tb/phy_mgmt_regs_bench.sv
module phy_mgmt_regs_bench;

   localparam int SRST = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [4:0]  strap_addr = 5'd0;
   logic [4:0]  acc_addr = 5'd0;
   logic        acc_wr = 1'b0, acc_rd = 1'b0;
   logic [15:0] acc_wdata = 16'h0;
   logic [15:0] acc_rdata;
   logic        link_up = 1'b1, an_done = 1'b0, rem_fault = 1'b0, jabber = 1'b0;
   logic        loopback, speed_100, an_enable, an_restart;
   logic        low_power, isolate, full_duplex, soft_rst;

   always #4 clk = ~clk;

   phy_mgmt_regs #(.SRST_CYC(SRST)) u_phy_mgmt_regs (
      .clk(clk), .rst_n(rst_n), .strap_addr(strap_addr),
      .acc_addr(acc_addr), .acc_wr(acc_wr), .acc_rd(acc_rd),
      .acc_wdata(acc_wdata), .acc_rdata(acc_rdata),
      .link_up(link_up), .an_done(an_done), .rem_fault(rem_fault), .jabber(jabber),
      .loopback(loopback), .speed_100(speed_100), .an_enable(an_enable),
      .an_restart(an_restart), .low_power(low_power), .isolate(isolate),
      .full_duplex(full_duplex), .soft_rst(soft_rst)
   );

   int checks = 0;
   int fails  = 0;
   logic [15:0] exp_q[$];
   string       tag_q[$];

   task automatic chk(input bit ok, input string tag, input logic [15:0] act,
                      input logic [15:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [15:0] d);
      acc_addr = a; acc_wdata = d; acc_wr = 1'b1;
      @(negedge clk);
      acc_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, input logic [15:0] e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      acc_addr = a; acc_rd = 1'b1;
      @(negedge clk);
      acc_rd = 1'b0;
   endtask

   task automatic hw_reset(input logic [4:0] s);
      strap_addr = s;
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // monitor: compare read data one cycle after each strobe
   initial begin
      forever begin
         @(posedge clk);
         if (acc_rd) begin
            @(negedge clk);
            if (exp_q.size() == 0) chk(1'b0, "R10 unexpected read", acc_rdata, 16'h0);
            else begin
               logic [15:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               chk(acc_rdata == e, t, acc_rdata, e);
            end
         end
      end
   end

   task automatic finish_run;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      finish_run();
   end

   initial begin
      int n;
      @(negedge clk);
      // strap zero: isolate default
      hw_reset(5'd0);
      chk(isolate == 1'b1, "R11 isolate out", {15'h0, isolate}, 16'h1);
      chk(acc_rdata == 16'h0, "R1 rdata after reset", acc_rdata, 16'h0);
      rd(5'd0, 16'h3500, "R11 ctrl default strap zero");

      // nonzero strap
      hw_reset(5'd5);
      chk({loopback, speed_100, an_enable, low_power, isolate, full_duplex} == 6'b011001,
          "R1 control outputs",
          {10'h0, loopback, speed_100, an_enable, low_power, isolate, full_duplex},
          16'h0019);
      chk({soft_rst, an_restart} == 2'b00, "R1 command outputs idle",
          {14'h0, soft_rst, an_restart}, 16'h0);
      rd(5'd0, 16'h3100, "R1 ctrl default");

      // writable bits, low byte masked
      wr(5'd0, 16'h61FF);
      chk({loopback, an_enable, full_duplex} == 3'b101, "R2 outputs after write",
          {13'h0, loopback, an_enable, full_duplex}, 16'h5);
      rd(5'd0, 16'h6100, "R2 readback 0x61FF");
      wr(5'd0, 16'h0C00);
      chk({low_power, isolate, speed_100} == 3'b110, "R2 low power isolate",
          {13'h0, low_power, isolate, speed_100}, 16'h6);
      rd(5'd0, 16'h0C00, "R2 readback 0x0C00");

      // negotiation restart
      wr(5'd0, 16'h1200);
      chk(an_restart == 1'b1, "R4 pulse high", {15'h0, an_restart}, 16'h1);
      @(negedge clk);
      chk(an_restart == 1'b0, "R4 pulse one cycle", {15'h0, an_restart}, 16'h0);
      rd(5'd0, 16'h1000, "R4 bit 9 cleared");

      // soft reset
      wr(5'd0, 16'h8000);
      chk(soft_rst == 1'b1, "R3 soft reset active", {15'h0, soft_rst}, 16'h1);
      rd(5'd0, 16'hB100, "R3 bit 15 and defaults during soft reset");
      wr(5'd0, 16'h4000);
      n = 0;
      while (soft_rst) begin
         @(negedge clk);
         n++;
      end
      chk(n == SRST - 2, "R3 soft reset length", 16'(n), 16'(SRST - 2));
      rd(5'd0, 16'h3100, "R3 write ignored and bit 15 clear");

      // status: link latched low from reset
      rd(5'd1, 16'h7809, "R5 link low after reset");
      rd(5'd1, 16'h780D, "R8 link reload");
      link_up = 1'b0; @(negedge clk); link_up = 1'b1;
      rd(5'd1, 16'h7809, "R5 link drop held");
      rd(5'd1, 16'h780D, "R8 link back after read");

      // latch-high events
      jabber = 1'b1; @(negedge clk); jabber = 1'b0;
      rd(5'd1, 16'h780F, "R6 jabber latched");
      rd(5'd1, 16'h780D, "R8 jabber cleared");
      an_done = 1'b1; rem_fault = 1'b1; @(negedge clk);
      an_done = 1'b0; rem_fault = 1'b0; @(negedge clk);
      rd(5'd1, 16'h783D, "R6 an_done and rem_fault latched");
      rd(5'd1, 16'h780D, "R8 events cleared");
      an_done = 1'b1;
      rd(5'd1, 16'h780D, "R8 event on read edge not yet shown");
      an_done = 1'b0;
      rd(5'd1, 16'h782D, "R8 event on read edge held");
      rd(5'd1, 16'h780D, "R8 event then cleared");

      // status write ignored, unmapped read
      wr(5'd1, 16'h0000);
      rd(5'd1, 16'h780D, "R9 status write ignored");
      rd(5'd3, 16'h0000, "R9 unmapped read zero");
      rd(5'd1, 16'h780D, "R7 fixed fields");

      // read data holds without strobe
      wr(5'd0, 16'h4000);
      repeat (3) @(negedge clk);
      chk(acc_rdata == 16'h780D, "R10 rdata holds", acc_rdata, 16'h780D);

      repeat (3) @(negedge clk);
      chk(exp_q.size() == 0, "R10 all reads returned", 16'(exp_q.size()), 16'h0);
      finish_run();
   end

endmodule